// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block moves data words from one clock domain into a second clock domain whose frequency and phase have no fixed relation to the first. The producer drives `push` with a word on `wr_data` in the write clock domain and stops while `full` is high. The consumer drives `pop` in the read clock domain while `empty` is low and takes the word from `rd_data` one read clock later. The depth is a power of two by construction, set through the address width.

Each side counts its accepted operations in a binary pointer that is one bit wider than the storage address. The top bit records how many times the pointer has wrapped. The side also keeps a registered Gray-coded copy of that pointer, and only the Gray copy crosses to the other side. It goes through a chain of at least two flops clocked by the receiving domain. The receiving side turns the synchronized Gray value back into binary. The write side forms `full` from the two binary pointers, and the read side forms `empty` from them. Both flags come from a delayed view of the far pointer, so they can stay asserted too long. They never clear too early.

The block has no state machine. Each pointer side works as a two-state rule: it accepts a request when its flag is low and refuses it when the flag is high.

Top module: `dcfifo`

## Requirements
- R1: While `rst_n` is low and after it is released, with no traffic, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: Every word accepted by a push appears on `rd_data` exactly once, unchanged and in push order.
- R3: Once DEPTH (8 by default) words have been accepted and none popped, `full` is 1 at the first write clock sample after the accepting edge.
- R4: A push while `full` is 1 is ignored. No word is stored, the write pointer does not move and stored words are not overwritten.
- R5: A pop while `empty` is 1 is ignored. The read pointer does not move and `rd_data` keeps its value.
- R6: `full` is never 0 while DEPTH words are unread, and `empty` is never 0 while no word is unread.
- R7: `rd_data` changes only on a read clock edge where a pop is accepted, and it then shows the popped word.
- R8: After a push into an empty FIFO, `empty` falls within SYNC_STAGES+1 read clock cycles.
- R9: Each Gray pointer that crosses domains changes in at most one bit per cycle of its own clock, including at the wrap of the pointer.
- R10: R2 and R6 hold when the read clock is faster than the write clock and when it is slower.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| push | input | 1 | Write request, qualified by `full` |
| wr_data | input | DATA_W | Word written on an accepted push |
| full | output | 1 | No free entry as seen by the write side |
| pop | input | 1 | Read request, qualified by `empty` |
| rd_data | output | DATA_W | Registered word from the last accepted pop |
| empty | output | 1 | No unread entry as seen by the read side |

## Verification
The hardest case to reach is a flag edge that meets an operation still crossing from the other domain. Two examples are `full` clearing just as a pop reaches the write side, and `empty` clearing just as the last unread word leaves. The bench drives long streams with random request gaps at several read and write clock ratios, so that these meetings fall on many different phase offsets. At each sample it compares the flags with a reference queue that is updated at the true accept edges. Separate directed runs fill the FIFO past capacity and pop an empty FIFO, to probe the refusal rule at both ends.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    // Which end of the FIFO a pointer controller serves.
    typedef enum logic {
        SIDE_WRITE = 1'b0,
        SIDE_READ  = 1'b1
    } side_e;

    // A crossing needs at least this many receiving flops.
    localparam int SYNC_MIN = 2;

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    import dcfifo_pkg::*;

    localparam int N = (STAGES < SYNC_MIN) ? SYNC_MIN : STAGES;

    logic [WIDTH-1:0] chain [N];

    genvar s;
    generate
        for (s = 0; s < N; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[N-1];

endmodule

// File: rtl/dcfifo_ptr_ctl.sv
module dcfifo_ptr_ctl
    import dcfifo_pkg::*;
#(
    parameter int    ADDR_W = 3,
    parameter side_e SIDE   = SIDE_WRITE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W:0]   peer_gray,   // far pointer, already synchronized
    output logic              flag,        // full (write side) or empty (read side)
    output logic              step,        // request accepted this cycle
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W:0]   own_bin,
    output logic [ADDR_W:0]   own_gray,
    output logic [ADDR_W:0]   peer_bin
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] bin_q;
    logic [PW-1:0] bin_d;
    logic [PW-1:0] gray_q;

    assign step  = req && !flag;
    assign bin_d = bin_q + {{ADDR_W{1'b0}}, step};

    // Pointer and its Gray image are both plain flops: nothing but a wire
    // sits between gray_q and the first synchronizer stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_d;
            gray_q <= bin_d ^ (bin_d >> 1);
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits.
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            peer_bin[i] = ^(peer_gray >> i);
        end
    end

    generate
        if (SIDE == SIDE_WRITE) begin : g_full
            assign flag = (bin_q[ADDR_W] != peer_bin[ADDR_W]) &&
                          (bin_q[ADDR_W-1:0] == peer_bin[ADDR_W-1:0]);
        end else begin : g_empty
            assign flag = (bin_q == peer_bin);
        end
    endgenerate

    assign addr     = bin_q[ADDR_W-1:0];
    assign own_bin  = bin_q;
    assign own_gray = gray_q;

endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              wr_clk,
    input  logic              wen,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              ren,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wen) cells[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n)   rdata <= '0;
        else if (ren) rdata <= cells[raddr];
    end

endmodule

// File: rtl/dcfifo.sv
module dcfifo #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);
    import dcfifo_pkg::*;

    localparam int PW = ADDR_W + 1;

    logic              w_step, r_step;
    logic [ADDR_W-1:0] w_addr, r_addr;
    logic [PW-1:0]     w_bin, w_gray, r_bin, r_gray;
    logic [PW-1:0]     w_gray_at_rd, r_gray_at_wr;
    logic [PW-1:0]     rq_bin, wq_bin;

    dcfifo_ptr_ctl #(.ADDR_W(ADDR_W), .SIDE(SIDE_WRITE)) u_wr_ctl (
        .clk(wr_clk), .rst_n(rst_n), .req(push), .peer_gray(r_gray_at_wr),
        .flag(full), .step(w_step), .addr(w_addr),
        .own_bin(w_bin), .own_gray(w_gray), .peer_bin(rq_bin)
    );

    dcfifo_ptr_ctl #(.ADDR_W(ADDR_W), .SIDE(SIDE_READ)) u_rd_ctl (
        .clk(rd_clk), .rst_n(rst_n), .req(pop), .peer_gray(w_gray_at_rd),
        .flag(empty), .step(r_step), .addr(r_addr),
        .own_bin(r_bin), .own_gray(r_gray), .peer_bin(wq_bin)
    );

    dcfifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(w_gray), .q(w_gray_at_rd)
    );

    dcfifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(r_gray), .q(r_gray_at_wr)
    );

    dcfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk(wr_clk), .wen(w_step), .waddr(w_addr), .wdata(wr_data),
        .rd_clk(rd_clk), .rst_n(rst_n), .ren(r_step), .raddr(r_addr),
        .rdata(rd_data)
    );

endmodule

// File: rtl/dcfifo_checker.sv
module dcfifo_checker #(
    parameter int ADDR_W = 3
) (
    input logic            wr_clk,
    input logic            rd_clk,
    input logic            rst_n,
    input logic            push,
    input logic            pop,
    input logic            full,
    input logic            empty,
    input logic [ADDR_W:0] w_bin,
    input logic [ADDR_W:0] w_gray,
    input logic [ADDR_W:0] r_bin,
    input logic [ADDR_W:0] r_gray,
    input logic [ADDR_W:0] rq_bin
);
    localparam logic [ADDR_W:0] DEPTH_P = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0] ONE_P   = {{ADDR_W{1'b0}}, 1'b1};

    logic [ADDR_W:0] w_occ;
    assign w_occ = w_bin - rq_bin;

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |=> $stable(w_bin)); // R4

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |=> $stable(r_bin)); // R5

    AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1); // R9

    AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1); // R9

    AST_OCCUPANCY_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n)
        w_occ <= DEPTH_P); // R6

    AST_WR_ADVANCE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (push && !full) |=> (w_bin == $past(w_bin) + ONE_P)); // R2

    AST_RD_ADVANCE: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (pop && !empty) |=> (r_bin == $past(r_bin) + ONE_P)); // R2

endmodule

bind dcfifo dcfifo_checker #(.ADDR_W(ADDR_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .push(push), .pop(pop), .full(full), .empty(empty),
    .w_bin(w_bin), .w_gray(w_gray), .r_bin(r_bin), .r_gray(r_gray),
    .rq_bin(rq_bin)
);

// File: tb/dcfifo_tb.sv
`timescale 1ns/1ps
module dcfifo_tb;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int SYNC  = 2;

    logic          wr_clk = 0;
    logic          rd_clk = 0;
    logic          rst_n  = 0;
    logic          push   = 0;
    logic          pop    = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          full, empty;

    realtime rhalf = 13.7;
    int      checks = 0;
    int      errors = 0;
    int      cyc    = 0;
    logic [DW-1:0] model [$];

    dcfifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .push(push), .wr_data(wr_data), .full(full),
        .pop(pop), .rd_data(rd_data), .empty(empty)
    );

    always #10 wr_clk = ~wr_clk;        // 50 MHz write clock
    always #(rhalf) rd_clk = ~rd_clk;   // read clock, period changed per test

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge wr_clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Writer: accepts n words (values base+k), push asserted with given odds (0..3 of 4 skipped).
    task automatic drive_writes(input int n, input int base, input int skip);
        int idx = 0;
        while (idx < n) begin
            logic f, want;
            @(negedge wr_clk);
            f = full;
            check(f || model.size() < DEPTH, "R6 full", model.size(), DEPTH - 1);
            want = (($urandom % 4) >= skip);
            push    = want;
            wr_data = DW'(base + idx);
            @(posedge wr_clk);
            if (want && !f) begin
                model.push_back(DW'(base + idx));
                idx++;
            end
        end
        @(negedge wr_clk);
        push = 0;
    endtask

    // Reader: accepts n pops and checks each word one read cycle later.
    task automatic drive_reads(input int n, input int skip);
        int got = 0;
        logic pend = 0;
        logic [DW-1:0] exp = '0;
        while (got < n || pend) begin
            logic e, want;
            @(negedge rd_clk);
            e = empty;
            check(e || model.size() > 0, "R6 empty", model.size(), 1);
            if (pend) begin
                check(rd_data == exp, "R2/R7 data", rd_data, exp);
                pend = 0;
            end
            want = (got < n) && (($urandom % 4) >= skip);
            pop  = want;
            @(posedge rd_clk);
            if (want && !e) begin
                exp  = model.pop_front();
                pend = 1;
                got++;
            end
        end
        pop = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge wr_clk);
        check(empty == 1, "R1 empty in reset", empty, 1);
        check(full == 0,  "R1 full in reset", full, 0);
        check(rd_data == 0, "R1 rd_data in reset", rd_data, 0);
        rst_n = 1;
        repeat (4) @(negedge rd_clk);
        check(empty == 1 && full == 0, "R1 flags after release", {full, empty}, 1);
    endtask

    task automatic t_fill_overflow();
        int acc = 0;
        for (int k = 0; k < DEPTH + 3; k++) begin
            logic f;
            @(negedge wr_clk);
            f = full;
            if (acc == DEPTH) check(f == 1, "R3 full after DEPTH pushes", f, 1);
            else              check(f == 0, "R6 full early", f, 0);
            push = 1;
            wr_data = DW'(8'h40 + k);
            @(posedge wr_clk);
            if (!f) begin
                model.push_back(DW'(8'h40 + k));
                acc++;
            end
        end
        @(negedge wr_clk);
        push = 0;
        check(full == 1, "R3 full holds", full, 1);
        check(acc == DEPTH, "R4 pushes while full ignored", acc, DEPTH);
        // Drain: words must be 0x40.. with nothing overwritten (R4, R2).
        drive_reads(DEPTH, 0);
        repeat (6) @(negedge wr_clk);
        check(empty == 1, "R6 empty after drain", empty, 1);
        check(full == 0,  "R4 full clears after drain", full, 0);
        check(model.size() == 0, "R2 model drained", model.size(), 0);
    endtask

    task automatic t_underflow_latency();
        logic [DW-1:0] held;
        int lat = 0;
        held = rd_data;
        for (int k = 0; k < 5; k++) begin
            @(negedge rd_clk);
            pop = 1;
        end
        @(negedge rd_clk);
        pop = 0;
        check(rd_data == held, "R5 pop while empty ignored", rd_data, held);
        check(empty == 1, "R5 still empty", empty, 1);
        // Single push, then measure how long empty stays high (R8).
        @(negedge wr_clk);
        push = 1;
        wr_data = 8'hA5;
        @(posedge wr_clk);
        model.push_back(8'hA5);
        @(negedge wr_clk);
        push = 0;
        while (empty && lat < 20) begin
            @(negedge rd_clk);
            lat++;
        end
        check(lat <= SYNC + 1, "R8 empty fall latency", lat, SYNC + 1);
        check(rd_data == held, "R7 rd_data held until pop", rd_data, held);
        drive_reads(1, 0);
        check(rd_data == 8'hA5, "R7 word after pop", rd_data, 8'hA5);
    endtask

    // Concurrent streams with random gaps; pointers wrap many times (R9, R10).
    task automatic t_stream(input realtime half, input int n, input int wskip, input int rskip);
        rhalf = half;
        repeat (3) @(negedge rd_clk);
        fork
            drive_writes(n, 0, wskip);
            drive_reads(n, rskip);
        join
        check(model.size() == 0, "R10 stream balanced", model.size(), 0);
        repeat (6) @(negedge rd_clk);
        check(empty == 1, "R10 empty at end of stream", empty, 1);
    endtask

    initial begin
        t_reset();
        t_fill_overflow();
        t_underflow_latency();
        t_stream(7.3, 300, 1, 0);    // read faster, writes sparse
        t_stream(31.1, 300, 0, 1);   // read slower, FIFO mostly full
        t_stream(10.0, 300, 2, 2);   // same period, phase shifted
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule